// File: doc/BRIEF.md
# Buffered Asynchronous Serial Receiver with Per-Character Error Flags

This block receives characters from an asynchronous serial line. A tick input, supplied from outside at a fixed multiple of the bit rate, paces a controller that validates each start bit, samples the data bits near the middle of each bit, optionally checks a parity bit, and samples the first stop bit. Characters can be five to nine bits wide. Each completed character, together with its own framing, parity and overrun flags, goes into a small FIFO of two entries. A holding register behind the FIFO keeps one more finished character until space opens.

Software-style access is a read port: the ninth data bit and the three flags of the oldest entry are visible at all times, and a pop strobe, the equivalent of reading the low byte, removes that entry. A ready flag tells whether unread characters remain, and an interrupt request combines it with a local and a global enable. An address-filter mode drops every frame whose ninth bit is clear, so a node on a shared line only wakes for address frames.

Top module: `serial_rx`

## Requirements
- R1: `rxReady` is 1 exactly when at least one unread character sits in the FIFO, and it is 0 after reset.
- R2: Holding `rxEnable` low for one clock empties the FIFO and the holding register and clears any pending loss, so `rxReady`, `frameErr`, `parityErr` and `overrun` read 0 afterwards; reception works normally once `rxEnable` returns high.
- R3: The FIFO keeps two characters in arrival order and one more waits in a holding register; when the FIFO is full, the holding register is occupied and a new start bit is validated, the held character is discarded and the next character stored carries `overrun` = 1.
- R4: `frameErr` of a character is 1 when its first stop bit is sampled as 0; only one stop bit is examined and the data is stored anyway.
- R5: `parityMode` 2'b10 selects even parity, 2'b11 odd parity, and 2'b00 or 2'b01 no parity bit; `parityErr` is 1 only when parity is enabled and the received parity bit disagrees with the selected mode.
- R6: The three flags belong to the character at the head of the FIFO; after a pop they show the flags of the next character.
- R7: With `addrFilter` = 1, a frame whose ninth bit is 0 is not stored; for sizes below nine bits the ninth bit counts as 0, so all such frames are dropped.
- R8: `rdData` shows the low eight bits and `rdBit8` the ninth bit of the head character (0 for sizes below nine); a one-clock `rdPop` removes the head so the ninth bit must be taken before popping.
- R9: `rxIrq` is 1 exactly when `rxIrqEn`, `globalIrqEn` and `rxReady` are all 1.
- R10: A start bit is accepted only when at least two of three samples taken around the middle of the bit are 0; otherwise the receiver returns to idle and stores nothing.
- R11: `charSize` codes 0, 1, 2, 3 give 5, 6, 7, 8 data bits and codes 4 to 7 give 9 bits; data arrives least significant bit first and unused upper bits read 0.
- R12: All sampling advances only on cycles with `osTick` high, with 16 ticks per bit by default, so the same frame is received whatever the tick spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| osTick | input | 1 | Oversampling tick, OVERSAMPLE per bit |
| rxLine | input | 1 | Serial input, idle high |
| rxEnable | input | 1 | Receiver enable; low flushes all stored characters |
| charSize | input | 3 | Data bits code: 0..3 -> 5..8, 4..7 -> 9 |
| parityMode | input | 2 | 2'b10 even, 2'b11 odd, otherwise none |
| addrFilter | input | 1 | Drop frames whose ninth bit is 0 |
| rdPop | input | 1 | Remove the head character |
| rxIrqEn | input | 1 | Local interrupt enable |
| globalIrqEn | input | 1 | Global interrupt enable |
| rdData | output | 8 | Low eight bits of the head character |
| rdBit8 | output | 1 | Ninth bit of the head character |
| rxReady | output | 1 | Unread characters present |
| frameErr | output | 1 | Head character had a bad stop bit |
| parityErr | output | 1 | Head character failed the parity check |
| overrun | output | 1 | A character was lost before the head character |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
The bench aims at the loss corner: four frames sent without reading must yield the first two, then the fourth with its overrun flag, and a design that tagged the wrong entry or dropped the wrong character returns the third frame or a clear flag. Flags sent with a queued pair of characters catch a design that shares one flag set across the FIFO, since the second character would show the first one's errors. A short low glitch on the line and frames sent with a slower tick catch designs that start on a single sample or count clocks instead of ticks, which would store garbage or lose bits. Filtered frames in nine-bit and eight-bit mode, odd and even parity with flipped parity bits, and a one-clock disable during a full FIFO expose filters, parity senses and flushes that are missing or inverted.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam int MAX_BITS = 9;

  // One stored character with its own error flags
  typedef struct packed {
    logic [MAX_BITS-1:0] data;
    logic                frameErr;
    logic                parityErr;
    logic                overrun;
  } rxEntry_t;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic       startOk;
    logic       dataEn;
    logic [3:0] bitIdx;
    logic       parEn;
    logic       stopEn;
    logic       bitVal;
  } rxStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rxState_t;

  function automatic logic [3:0] bitsForSize(input logic [2:0] code);
    if (code >= 3'd4) return 4'd9;
    return {1'b0, code} + 4'd5;
  endfunction

endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEnable,
  input  logic       osTick,
  input  logic       rxLine,
  input  logic [2:0] charSize,
  input  logic [1:0] parityMode,
  output rxStrobe_t  strb
);

  localparam int CW      = $clog2(OVERSAMPLE);
  localparam int MID     = OVERSAMPLE / 2;
  localparam int LAST    = OVERSAMPLE - 1;
  localparam int STOP_AT = MID + 2;

  logic       syncA, rxS;
  rxState_t   state;
  logic [CW-1:0] tickCnt;
  logic [3:0] bitIdx;
  logic [2:0] votes;
  logic       majority;
  logic [3:0] nBits;
  logic       atLast, inVote;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b1;
      rxS   <= 1'b1;
    end else begin
      syncA <= rxLine;
      rxS   <= syncA;
    end
  end

  assign majority = (votes[0] & votes[1]) | (votes[0] & votes[2]) | (votes[1] & votes[2]);
  assign nBits    = bitsForSize(charSize);
  assign atLast   = (tickCnt == CW'(LAST));
  assign inVote   = (tickCnt == CW'(MID - 1)) || (tickCnt == CW'(MID)) || (tickCnt == CW'(MID + 1));

  always_comb begin
    strb        = '0;
    strb.bitIdx = bitIdx;
    strb.bitVal = majority;
    if (rxEnable && osTick) begin
      case (state)
        ST_START:  strb.startOk = atLast && !majority;
        ST_DATA:   strb.dataEn  = atLast;
        ST_PARITY: strb.parEn   = atLast;
        ST_STOP:   strb.stopEn  = (tickCnt == CW'(STOP_AT));
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !rxEnable) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      votes   <= 3'b111;
    end else if (osTick) begin
      if (state == ST_IDLE) begin
        if (!rxS) begin
          state   <= ST_START;
          tickCnt <= CW'(1);
        end
      end else begin
        tickCnt <= atLast ? '0 : tickCnt + CW'(1);
        if (inVote) votes <= {votes[1:0], rxS};
        case (state)
          ST_START: if (atLast) begin
            state  <= majority ? ST_IDLE : ST_DATA;
            bitIdx <= '0;
          end
          ST_DATA: if (atLast) begin
            if (bitIdx == nBits - 4'd1) state <= parityMode[1] ? ST_PARITY : ST_STOP;
            else bitIdx <= bitIdx + 4'd1;
          end
          ST_PARITY: if (atLast) state <= ST_STOP;
          ST_STOP: if (tickCnt == CW'(STOP_AT)) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R4: only the first stop bit is examined, then the receiver idles
  p_stop_to_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.stopEn |=> (state == ST_IDLE));

  // R10: a start bit voted high sends the receiver back to idle
  p_false_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && osTick && state == ST_START && atLast && majority) |=> (state == ST_IDLE));

endmodule

// File: rtl/serial_rx_dp.sv
module serial_rx_dp
  import serial_rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEnable,
  input  rxStrobe_t  strb,
  input  logic [1:0] parityMode,
  input  logic       addrFilter,
  input  logic       rdPop,
  output rxEntry_t   headEntry,
  output logic       notEmpty
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  rxEntry_t            mem [DEPTH];
  logic [PW-1:0]       rdPtr, wrPtr;
  logic [CW-1:0]       count;
  logic [MAX_BITS-1:0] shreg;
  logic                parAcc, parRx;
  rxEntry_t            hold, newEntry;
  logic                holdValid, lostPending;
  logic                full, popOk, pushOk, keepFrame, dropHold;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full      = (count == CW'(DEPTH));
  assign notEmpty  = (count != '0);
  assign popOk     = rdPop && notEmpty;
  assign pushOk    = holdValid && (!full || popOk);
  assign keepFrame = strb.stopEn && !(addrFilter && !shreg[MAX_BITS-1]);
  assign dropHold  = strb.startOk && holdValid && !pushOk;

  always_comb begin
    newEntry.data      = shreg;
    newEntry.frameErr  = !strb.bitVal;
    newEntry.parityErr = parityMode[1] && ((parAcc ^ parRx) != parityMode[0]);
    newEntry.overrun   = lostPending;
  end

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= hold;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shreg       <= '0;
      parAcc      <= 1'b0;
      parRx       <= 1'b0;
      rdPtr       <= '0;
      wrPtr       <= '0;
      count       <= '0;
      hold        <= '0;
      holdValid   <= 1'b0;
      lostPending <= 1'b0;
    end else if (!rxEnable) begin
      rdPtr       <= '0;
      wrPtr       <= '0;
      count       <= '0;
      holdValid   <= 1'b0;
      lostPending <= 1'b0;
    end else begin
      if (strb.startOk) begin
        shreg  <= '0;
        parAcc <= 1'b0;
      end
      if (strb.dataEn) begin
        shreg  <= shreg | (MAX_BITS'(strb.bitVal) << strb.bitIdx);
        parAcc <= parAcc ^ strb.bitVal;
      end
      if (strb.parEn) parRx <= strb.bitVal;
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk)  rdPtr <= nextPtr(rdPtr);
      count <= count + CW'(pushOk) - CW'(popOk);
      if (keepFrame) begin
        hold        <= newEntry;
        holdValid   <= 1'b1;
        lostPending <= 1'b0;
      end else if (pushOk || dropHold) begin
        holdValid <= 1'b0;
      end
      if (dropHold) lostPending <= 1'b1;
    end
  end

  assign headEntry = mem[rdPtr];

  // R3: the FIFO never holds more than DEPTH characters
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  // R3: a character can only be lost while the FIFO is full
  p_loss_needs_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lostPending) |-> ($past(count) == CW'(DEPTH)));

  // R2: a disabled receiver keeps nothing
  p_disable_flush_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (count == '0 && !holdValid));

  // R7: a filtered frame never reaches the holding register
  p_filter_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stopEn && addrFilter && !shreg[MAX_BITS-1]) |=> !holdValid);

endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DEPTH      = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       osTick,
  input  logic       rxLine,
  input  logic       rxEnable,
  input  logic [2:0] charSize,
  input  logic [1:0] parityMode,
  input  logic       addrFilter,
  input  logic       rdPop,
  input  logic       rxIrqEn,
  input  logic       globalIrqEn,
  output logic [7:0] rdData,
  output logic       rdBit8,
  output logic       rxReady,
  output logic       frameErr,
  output logic       parityErr,
  output logic       overrun,
  output logic       rxIrq
);

  rxStrobe_t strb;
  rxEntry_t  headEntry;
  logic      notEmpty;

  serial_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rxEnable   (rxEnable),
    .osTick     (osTick),
    .rxLine     (rxLine),
    .charSize   (charSize),
    .parityMode (parityMode),
    .strb       (strb)
  );

  serial_rx_dp #(.DEPTH(DEPTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxEnable   (rxEnable),
    .strb       (strb),
    .parityMode (parityMode),
    .addrFilter (addrFilter),
    .rdPop      (rdPop),
    .headEntry  (headEntry),
    .notEmpty   (notEmpty)
  );

  assign rxReady   = notEmpty;
  assign rdData    = notEmpty ? headEntry.data[7:0] : 8'h00;
  assign rdBit8    = notEmpty & headEntry.data[8];
  assign frameErr  = notEmpty & headEntry.frameErr;
  assign parityErr = notEmpty & headEntry.parityErr;
  assign overrun   = notEmpty & headEntry.overrun;
  assign rxIrq     = rxIrqEn & globalIrqEn & notEmpty;

endmodule

// File: tb/serial_rx_tb.sv
module serial_rx_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       osTick;
  logic       rxLine = 1'b1;
  logic       rxEnable = 1'b1;
  logic [2:0] charSize = 3'd3;
  logic [1:0] parityMode = 2'b00;
  logic       addrFilter = 1'b0;
  logic       rdPop = 1'b0;
  logic       rxIrqEn = 1'b0;
  logic       globalIrqEn = 1'b0;
  logic [7:0] rdData;
  logic       rdBit8, rxReady, frameErr, parityErr, overrun, rxIrq;

  int checks = 0;
  int errors = 0;
  int tickEvery = 1;
  int tickCnt = 0;
  bit done = 0;
  int unsigned seed = 32'd1234;

  always #4 clk = ~clk;

  always @(posedge clk) tickCnt <= (tickCnt + 1 >= tickEvery) ? 0 : tickCnt + 1;
  assign osTick = (tickCnt == 0);

  serial_rx u_dut (
    .clk(clk), .rstN(rstN), .osTick(osTick), .rxLine(rxLine), .rxEnable(rxEnable),
    .charSize(charSize), .parityMode(parityMode), .addrFilter(addrFilter), .rdPop(rdPop),
    .rxIrqEn(rxIrqEn), .globalIrqEn(globalIrqEn), .rdData(rdData), .rdBit8(rdBit8),
    .rxReady(rxReady), .frameErr(frameErr), .parityErr(parityErr), .overrun(overrun), .rxIrq(rxIrq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sizeBits(input logic [2:0] code);
    return (code >= 3'd4) ? 9 : int'(code) + 5;
  endfunction

  function automatic logic [8:0] maskData(input logic [8:0] d, input int nb);
    logic [8:0] m = '0;
    for (int i = 0; i < nb; i++) m[i] = d[i];
    return m;
  endfunction

  task automatic sendBit(input logic v);
    rxLine = v;
    repeat (16 * tickEvery) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [8:0] d, input bit badPar, input bit badStop);
    int nb = sizeBits(charSize);
    logic [8:0] m = maskData(d, nb);
    sendBit(1'b0);
    for (int i = 0; i < nb; i++) sendBit(m[i]);
    if (parityMode[1]) sendBit((^m) ^ parityMode[0] ^ badPar);
    sendBit(!badStop);
    rxLine = 1'b1;
    repeat (24 * tickEvery) @(negedge clk);
  endtask

  task automatic expectHead(input string req, input logic [8:0] d, input bit fe, input bit pe, input bit ov);
    logic [8:0] m = maskData(d, sizeBits(charSize));
    chk(req, "ready", int'(rxReady), 1);
    chk(req, "rdData", int'(rdData), int'(m[7:0]));
    chk(req, "rdBit8", int'(rdBit8), int'(m[8]));
    chk(req, "frameErr", int'(frameErr), int'(fe));
    chk(req, "parityErr", int'(parityErr), int'(pe));
    chk(req, "overrun", int'(overrun), int'(ov));
    rdPop = 1'b1;
    @(negedge clk);
    rdPop = 1'b0;
  endtask

  task automatic expectEmpty(input string req);
    chk(req, "ready empty", int'(rxReady), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(seed));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1", "reset ready", int'(rxReady), 0);
    chk("R9", "reset irq", int'(rxIrq), 0);
    chk("R6", "reset flags", int'({frameErr, parityErr, overrun}), 0);

    // R11 / R8: eight-bit and five-bit frames
    charSize = 3'd3;
    sendFrame(9'h0A5, 0, 0);
    expectHead("R11 8-bit", 9'h0A5, 0, 0, 0);
    expectEmpty("R1 after pop");
    charSize = 3'd0;
    sendFrame(9'h1F5, 0, 0);
    expectHead("R11 5-bit", 9'h1F5, 0, 0, 0);
    charSize = 3'd2;
    sendFrame(9'h17F, 0, 0);
    expectHead("R11 7-bit", 9'h17F, 0, 0, 0);

    // R8: ninth bit
    charSize = 3'd4;
    sendFrame(9'h1C3, 0, 0);
    chk("R8", "ninth bit before pop", int'(rdBit8), 1);
    expectHead("R8 9-bit", 9'h1C3, 0, 0, 0);
    expectEmpty("R8 popped");

    // R5: parity modes
    charSize = 3'd3;
    parityMode = 2'b10;
    sendFrame(9'h033, 0, 0);
    expectHead("R5 even good", 9'h033, 0, 0, 0);
    sendFrame(9'h033, 1, 0);
    expectHead("R5 even bad", 9'h033, 0, 1, 0);
    parityMode = 2'b11;
    sendFrame(9'h071, 0, 0);
    expectHead("R5 odd good", 9'h071, 0, 0, 0);
    sendFrame(9'h071, 1, 0);
    expectHead("R5 odd bad", 9'h071, 0, 1, 0);
    parityMode = 2'b01;
    sendFrame(9'h0C4, 0, 0);
    expectHead("R5 mode 01 no parity", 9'h0C4, 0, 0, 0);

    // R4: frame error
    parityMode = 2'b00;
    sendFrame(9'h05A, 0, 1);
    expectHead("R4 bad stop", 9'h05A, 1, 0, 0);
    expectEmpty("R4 no extra char");

    // R6: per-entry flags
    parityMode = 2'b10;
    sendFrame(9'h011, 1, 0);
    sendFrame(9'h022, 0, 1);
    expectHead("R6 first entry", 9'h011, 0, 1, 0);
    expectHead("R6 second entry", 9'h022, 1, 0, 0);
    parityMode = 2'b00;

    // R3: overrun
    sendFrame(9'h001, 0, 0);
    sendFrame(9'h002, 0, 0);
    sendFrame(9'h003, 0, 0);
    chk("R1", "ready with full fifo", int'(rxReady), 1);
    sendFrame(9'h004, 0, 0);
    expectHead("R3 first", 9'h001, 0, 0, 0);
    expectHead("R3 second", 9'h002, 0, 0, 0);
    expectHead("R3 after loss", 9'h004, 0, 0, 1);
    expectEmpty("R3 third lost");

    // R2: disable flushes
    sendFrame(9'h0AA, 0, 1);
    sendFrame(9'h0BB, 0, 0);
    sendFrame(9'h0CC, 0, 0);
    sendFrame(9'h0DD, 0, 0);
    rxEnable = 1'b0;
    @(negedge clk);
    rxEnable = 1'b1;
    @(negedge clk);
    chk("R2", "ready after disable", int'(rxReady), 0);
    chk("R2", "flags after disable", int'({frameErr, parityErr, overrun}), 0);
    sendFrame(9'h066, 0, 0);
    expectHead("R2 re-enabled, no overrun", 9'h066, 0, 0, 0);

    // R7: address filter
    addrFilter = 1'b1;
    charSize = 3'd4;
    sendFrame(9'h045, 0, 0);
    chk("R7", "data frame dropped", int'(rxReady), 0);
    sendFrame(9'h145, 0, 0);
    expectHead("R7 address frame kept", 9'h145, 0, 0, 0);
    charSize = 3'd3;
    sendFrame(9'h0FF, 0, 0);
    chk("R7", "8-bit frame dropped", int'(rxReady), 0);
    addrFilter = 1'b0;

    // R10: false start
    rxLine = 1'b0;
    repeat (4) @(negedge clk);
    rxLine = 1'b1;
    repeat (60) @(negedge clk);
    chk("R10", "glitch stores nothing", int'(rxReady), 0);
    sendFrame(9'h0E7, 0, 0);
    expectHead("R10 frame after glitch", 9'h0E7, 0, 0, 0);

    // R9: interrupt
    sendFrame(9'h012, 0, 0);
    for (int k = 0; k < 4; k++) begin
      rxIrqEn = k[0];
      globalIrqEn = k[1];
      @(negedge clk);
      chk("R9", "irq with char", int'(rxIrq), (k == 3) ? 1 : 0);
    end
    expectHead("R9 drain", 9'h012, 0, 0, 0);
    chk("R9", "irq empty", int'(rxIrq), 0);
    rxIrqEn = 1'b0;
    globalIrqEn = 1'b0;

    // R12: slower ticks
    tickEvery = 3;
    parityMode = 2'b11;
    sendFrame(9'h09C, 0, 0);
    expectHead("R12 tick every 3", 9'h09C, 0, 0, 0);
    tickEvery = 1;

    // Random frames
    for (int n = 0; n < 40; n++) begin
      logic [8:0] d;
      bit bp, bs;
      charSize = 3'($urandom_range(0, 7));
      parityMode = 2'($urandom_range(0, 3));
      d = 9'($urandom);
      bs = ($urandom_range(0, 7) == 0);
      bp = parityMode[1] && ($urandom_range(0, 7) == 0);
      sendFrame(d, bp, bs);
      expectHead("R11 R5 R4 random", d, bs, bp, 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule